// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the general-purpose integer registers of a processor that uses overlapping register windows. A 5-bit architectural register number is split into a frame select (upper two bits) and an offset (lower three bits). Frame 0 addresses one of several banks of global registers. Frames 1, 2 and 3 (outputs, locals, inputs) address segments of a ring of physical window segments. The current window pointer picks the ring position, and the global-level selector picks the global bank. Because the input frame of one window is the output frame of its neighbour, arguments pass between caller and callee without any copying.

The file has two combinational read ports and one write port that commits on the clock edge. Each port also drives out the physical index its register number resolves to, so the pipeline can track dependences on physical registers. Both selector inputs take effect on the mapping at once, with no register stage between them and the mapping. A synchronous clear zeroes the whole physical store.

Top module: `rwin_regfile`

## Requirements
- R1: With NG global banks and NW windows, base = ((NW − cwp) mod NW)×2. Outputs (register numbers 8–15) map to segment base, locals (16–23) to base+1, and inputs (24–31) to (base+2) mod 2·NW. The physical index is NG·8 + segment·8 + offset, and it is driven on every port's flat output.
- R2: The inputs frame at cwp = c resolves to the same physical registers as the outputs frame at cwp = (c−1) mod NW, including the wrap between cwp 0 and cwp NW−1. Data written through one frame is read back through the other.
- R3: Globals (register numbers 0–7) map to physical index gl·8 + offset. A gl value of NG or above selects bank NG−1. Each bank holds its own data.
- R4: Register number 0 reads as zero for every gl, and a write to it changes nothing.
- R5: Read data and flat indices follow cwp, gl and the register numbers in the same cycle, with no clock edge in between.
- R6: A write stores data at the physical register given by the cwp and gl present in its own cycle. The data is readable in the cycle after that edge.
- R7: A read of a register that is being written in the same cycle returns the value held before the write.
- R8: A clear pulse zeroes every global bank and window segment at one clock edge. A write in the same cycle is discarded.
- R9: While reset is asserted the store is zero and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the whole store |
| cwp | input | CW | Current window pointer |
| gl | input | GLW | Global bank selector |
| rd_a_idx | input | 5 | Read port A register number |
| rd_a_data | output | DW | Read port A data |
| rd_a_flat | output | FW | Read port A physical index |
| rd_b_idx | input | 5 | Read port B register number |
| rd_b_data | output | DW | Read port B data |
| rd_b_flat | output | FW | Read port B physical index |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register number |
| wr_data | input | DW | Write data |
| wr_flat | output | FW | Write port physical index |

## Verification
Flat indices and read data are combinational, so they are due in the cycle their inputs change. The bench drives new values on the falling edge and compares one nanosecond later, before any rising edge. A write or clear is due one rising edge later, so the bench drops the enable on the next falling edge and reads back only after that. The read-during-write case is compared before the edge and again after it, which shows the old value first and then the new one.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int unsigned FRAME_REGS = 8;

  typedef enum logic [1:0] {
    FR_GLOBAL = 2'd0,
    FR_OUT    = 2'd1,
    FR_LOCAL  = 2'd2,
    FR_IN     = 2'd3
  } frame_e;

  // first segment of the current window's outputs
  function automatic int unsigned win_base(int unsigned cwp, int unsigned nw);
    int unsigned c;
    c = cwp % nw;
    return ((nw - c) % nw) * 2;
  endfunction

  // segment of the ring addressed by a windowed frame
  function automatic int unsigned seg_of(frame_e fr, int unsigned cwp, int unsigned nw);
    int unsigned b;
    b = win_base(cwp, nw);
    case (fr)
      FR_OUT:   return b;
      FR_LOCAL: return b + 1;
      default:  return (b + 2) % (2 * nw);
    endcase
  endfunction

  // physical index of an architectural register number
  function automatic int unsigned flat_index(logic [4:0] idx, int unsigned cwp,
                                             int unsigned gl, int unsigned nw,
                                             int unsigned ng);
    frame_e      fr;
    int unsigned off;
    int unsigned g;
    fr  = frame_e'(idx[4:3]);
    off = 32'(idx[2:0]);
    g   = (gl >= ng) ? ng - 1 : gl;
    if (fr == FR_GLOBAL) return (g * FRAME_REGS) | off;
    return (ng * FRAME_REGS + seg_of(fr, cwp, nw) * FRAME_REGS) | off;
  endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int NW  = 8,
  parameter int NG  = 3,
  parameter int CW  = 3,
  parameter int GLW = 2,
  parameter int FW  = 8
) (
  input  logic [4:0]     idx,
  input  logic [CW-1:0]  cwp,
  input  logic [GLW-1:0] gl,
  output logic [FW-1:0]  flat,
  output logic           is_r0
);

  always_comb begin
    flat  = FW'(flat_index(idx, 32'(cwp), 32'(gl), NW, NG));
    is_r0 = (idx == 5'd0);
  end

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int DEPTH = 152,
  parameter int DW    = 32,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // reads see the array before this edge's write
  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
  import rwin_pkg::*;
#(
  parameter  int NW    = 8,
  parameter  int NG    = 3,
  parameter  int DW    = 32,
  localparam int CW    = (NW > 1) ? $clog2(NW) : 1,
  localparam int GLW   = (NG > 1) ? $clog2(NG) : 1,
  localparam int DEPTH = FRAME_REGS * (NG + 2 * NW),
  localparam int FW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [CW-1:0]  cwp,
  input  logic [GLW-1:0] gl,
  input  logic [4:0]     rd_a_idx,
  output logic [DW-1:0]  rd_a_data,
  output logic [FW-1:0]  rd_a_flat,
  input  logic [4:0]     rd_b_idx,
  output logic [DW-1:0]  rd_b_data,
  output logic [FW-1:0]  rd_b_flat,
  input  logic           wr_en,
  input  logic [4:0]     wr_idx,
  input  logic [DW-1:0]  wr_data,
  output logic [FW-1:0]  wr_flat
);

  localparam int NPORT = 3;  // 0: read A, 1: read B, 2: write

  logic [4:0]    map_idx  [NPORT];
  logic [FW-1:0] map_flat [NPORT];
  logic          map_r0   [NPORT];

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rwin_map #(
      .NW(NW), .NG(NG), .CW(CW), .GLW(GLW), .FW(FW)
    ) u_map (
      .idx  (map_idx[p]),
      .cwp  (cwp),
      .gl   (gl),
      .flat (map_flat[p]),
      .is_r0(map_r0[p])
    );
  end

  // named event: a write that will actually land in the store
  logic wr_fire;
  assign wr_fire = wr_en & ~map_r0[2] & ~clr;

  logic [DW-1:0] raw_a, raw_b;

  rwin_store #(
    .DEPTH(DEPTH), .DW(DW), .AW(FW)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .we     (wr_fire),
    .waddr  (map_flat[2]),
    .wdata  (wr_data),
    .raddr_a(map_flat[0]),
    .raddr_b(map_flat[1]),
    .rdata_a(raw_a),
    .rdata_b(raw_b)
  );

  assign rd_a_flat = map_flat[0];
  assign rd_b_flat = map_flat[1];
  assign wr_flat   = map_flat[2];
  assign rd_a_data = map_r0[0] ? '0 : raw_a;
  assign rd_b_data = map_r0[1] ? '0 : raw_b;

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
  parameter  int NW    = 8,
  parameter  int NG    = 3,
  parameter  int DW    = 32,
  localparam int CW    = (NW > 1) ? $clog2(NW) : 1,
  localparam int GLW   = (NG > 1) ? $clog2(NG) : 1,
  localparam int DEPTH = 8 * (NG + 2 * NW),
  localparam int FW    = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic [CW-1:0]  cwp,
  input logic [GLW-1:0] gl,
  input logic [4:0]     rd_a_idx,
  input logic [DW-1:0]  rd_a_data,
  input logic [FW-1:0]  rd_a_flat,
  input logic [4:0]     rd_b_idx,
  input logic [DW-1:0]  rd_b_data,
  input logic [FW-1:0]  rd_b_flat,
  input logic           wr_en,
  input logic [4:0]     wr_idx,
  input logic [DW-1:0]  wr_data,
  input logic [FW-1:0]  wr_flat,
  input logic           wr_fire
);

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

  assert_global_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx[4:3] == 2'd0) |-> (32'(rd_b_flat) < 32'(NG * 8)));

  assert_window_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx[4:3] != 2'd0) |->
      ((32'(rd_a_flat) >= 32'(NG * 8)) && (32'(rd_a_flat) < 32'(DEPTH))));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((rd_a_data == '0) && (rd_b_data == '0)));

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ((rd_a_flat != $past(wr_flat)) || (rd_a_data == $past(wr_data))));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> ((rd_b_flat != $past(rd_b_flat)) || $stable(rd_b_data)));

endmodule

bind rwin_regfile rwin_regfile_chk #(.NW(NW), .NG(NG), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cwp(cwp), .gl(gl),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_flat(rd_a_flat),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_flat(rd_b_flat),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_flat(wr_flat),
  .wr_fire(wr_fire)
);

// File: tb/rwin_regfile_test.sv
`timescale 1ns/1ps
module rwin_regfile_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  cwp = '0;
  logic [1:0]  gl = '0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic [7:0]  rd_a_flat, rd_b_flat, wr_flat;
  logic        wr_en = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rwin_regfile #(.NW(8), .NG(3), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cwp(cwp), .gl(gl),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_a_flat(rd_a_flat),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .rd_b_flat(rd_b_flat),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_flat(wr_flat)
  );

  // {cwp[2:0], gl[1:0], idx[4:0], expected flat[7:0]}, NW=8, NG=3
  localparam logic [17:0] VEC [12] = '{
    {3'd0, 2'd0, 5'd8,  8'd24},   // R1 outputs, window 0
    {3'd0, 2'd0, 5'd16, 8'd32},   // R1 locals
    {3'd0, 2'd0, 5'd24, 8'd40},   // R1 inputs
    {3'd1, 2'd0, 5'd8,  8'd136},  // R1 base 14
    {3'd1, 2'd0, 5'd21, 8'd149},  // R1 locals offset 5
    {3'd2, 2'd0, 5'd26, 8'd138},  // R1 inputs offset 2
    {3'd5, 2'd0, 5'd12, 8'd76},   // R1 base 6
    {3'd7, 2'd0, 5'd8,  8'd40},   // R2 equals inputs of window 0
    {3'd1, 2'd0, 5'd31, 8'd31},   // R2 wraps to segment 0
    {3'd0, 2'd1, 5'd3,  8'd11},   // R3 bank 1
    {3'd0, 2'd2, 5'd7,  8'd23},   // R3 bank 2
    {3'd0, 2'd3, 5'd1,  8'd17}    // R3 clamp to bank 2
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] c, input logic [1:0] g,
                          input logic [4:0] i, input logic [31:0] d);
    @(negedge clk);
    cwp = c; gl = g; wr_idx = i; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_at(input logic [2:0] c, input logic [1:0] g, input logic [4:0] i);
    cwp = c; gl = g; rd_a_idx = i; rd_b_idx = i;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: write attempted during reset is ignored, store reads zero
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hDEAD_BEEF; cwp = 3'd0;
    rd_a_idx = 5'd9;
    #1 chk(rd_a_data, 32'h0, "R9 reset read");
    repeat (2) @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    rd_at(3'd0, 2'd0, 5'd9);
    chk(rd_a_data, 32'h0, "R9 write during reset ignored");
    chk(32'(rd_a_flat), 32'd25, "R1 flat after reset");

    // R1 R2 R3: mapping table on all three ports
    foreach (VEC[k]) begin
      @(negedge clk);
      cwp = VEC[k][17:15]; gl = VEC[k][14:13];
      rd_a_idx = VEC[k][12:8]; rd_b_idx = VEC[k][12:8]; wr_idx = VEC[k][12:8];
      #1;
      chk(32'(rd_a_flat), 32'(VEC[k][7:0]), $sformatf("R1/R2/R3 vec %0d port A", k));
      chk(32'(rd_b_flat), 32'(VEC[k][7:0]), $sformatf("R1/R2/R3 vec %0d port B", k));
      chk(32'(wr_flat),   32'(VEC[k][7:0]), $sformatf("R1/R2/R3 vec %0d write", k));
    end

    // R2 data path: inputs of window 0 written, seen as outputs of window 7
    do_write(3'd0, 2'd0, 5'd24, 32'h1111_0024);
    rd_at(3'd7, 2'd0, 5'd8);
    chk(rd_a_data, 32'h1111_0024, "R2 overlap wrap data");
    rd_at(3'd0, 2'd0, 5'd24);
    chk(rd_b_data, 32'h1111_0024, "R6 readback same window");
    // R5: change cwp without a clock edge, the view moves at once
    rd_at(3'd1, 2'd0, 5'd24);
    chk(rd_a_data, 32'h0, "R5 immediate remap");
    chk(32'(rd_a_flat), 32'd24, "R5 immediate flat");

    // R6: write uses the cwp of its own cycle
    do_write(3'd3, 2'd0, 5'd17, 32'h3333_0017);
    rd_at(3'd4, 2'd0, 5'd17);
    chk(rd_a_data, 32'h0, "R6 other window untouched");
    rd_at(3'd3, 2'd0, 5'd17);
    chk(rd_a_data, 32'h3333_0017, "R6 written window");

    // R4: register 0 stays zero
    do_write(3'd0, 2'd1, 5'd0, 32'hFFFF_FFFF);
    rd_at(3'd0, 2'd1, 5'd0);
    chk(rd_a_data, 32'h0, "R4 r0 bank 1");
    rd_at(3'd0, 2'd0, 5'd0);
    chk(rd_b_data, 32'h0, "R4 r0 bank 0");

    // R3: banks hold separate data
    do_write(3'd0, 2'd0, 5'd5, 32'hC0C0_0005);
    do_write(3'd0, 2'd1, 5'd5, 32'hD1D1_0005);
    rd_at(3'd0, 2'd0, 5'd5);
    chk(rd_a_data, 32'hC0C0_0005, "R3 bank 0 data");
    rd_at(3'd0, 2'd1, 5'd5);
    chk(rd_a_data, 32'hD1D1_0005, "R3 bank 1 data");
    rd_at(3'd0, 2'd2, 5'd5);
    chk(rd_a_data, 32'h0, "R3 bank 2 data");

    // R7: read and write the same register in one cycle
    @(negedge clk);
    cwp = 3'd0; gl = 2'd0; rd_a_idx = 5'd5;
    wr_idx = 5'd5; wr_data = 32'hEEEE_0005; wr_en = 1'b1;
    #1 chk(rd_a_data, 32'hC0C0_0005, "R7 old value during write");
    @(negedge clk);
    wr_en = 1'b0;
    #1 chk(rd_a_data, 32'hEEEE_0005, "R7 new value after edge");

    // R8: clear beats a simultaneous write
    @(negedge clk);
    clr = 1'b1; wr_en = 1'b1; wr_idx = 5'd6; wr_data = 32'h6666_6666;
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    rd_at(3'd0, 2'd0, 5'd6);
    chk(rd_a_data, 32'h0, "R8 write discarded by clear");
    rd_at(3'd0, 2'd0, 5'd5);
    chk(rd_a_data, 32'h0, "R8 global cleared");
    rd_at(3'd3, 2'd0, 5'd17);
    chk(rd_a_data, 32'h0, "R8 window cleared");
    rd_at(3'd7, 2'd0, 5'd8);
    chk(rd_b_data, 32'h0, "R8 wrap segment cleared");

    finish_run();
  end

endmodule